// File: doc/BRIEF.md
# Double-Buffered Center/Edge-Aligned PWM Channel

This block is a 16-bit pulse-width timer with a single output pin. Its counter runs either as an up-counter that wraps at the modulo limit (edge-aligned) or as an up/down counter that turns around at the modulo limit and at zero (center-aligned). Software loads the modulo and the duty (compare) value one byte at a time through an 8-bit write port. Each value is held in a shadow buffer and reaches the active register only once a complete high/low byte pair has arrived.

While the counter is running, a completed pair is committed on the clock edge where the count steps from one below the limit to the limit. A period is therefore never cut short or stretched by a half-written value. While the clock-select field is zero the counter is frozen and a completed pair is loaded on the next cycle. A debug-halt input freezes the counter. A control write made during a halt discards a half-written modulo pair.

Top module: `bufpwm_top`

## Requirements
- R1: Write addresses are 0 = control, 1 = modulo high byte, 2 = modulo low byte, 3 = duty high byte, 4 = duty low byte. A high-byte write alone never changes the active value. The pair becomes eligible only after the following low-byte write.
- R2: Control bits [1:0] are the clock select (zero = stopped) and bit 2 selects center-aligned mode. The limit is the modulo value, or 0xFFFF when the modulo is zero. When running in edge mode the count goes 0..limit and then wraps to 0. In center mode it counts up to the limit, then down to 0, then up again.
- R3: While running, a completed duty or modulo pair is applied on the edge where the count steps from limit-1 to limit. It is not applied earlier.
- R4: In edge mode the output is high exactly while count < duty. A duty of 0 keeps the output low in either mode.
- R5: In center mode the output is high while count < duty. A duty equal to or above the limit gives a constant high output.
- R6: In center mode a duty of limit-1 gives an output that is low for exactly three counts per period (limit-1 rising, limit, limit-1 falling).
- R7: When the duty changes between zero and non-zero, the output follows the old value until the commit edge and the new value from then on.
- R8: With the clock select at zero the count holds, and a completed pair is loaded into the active register one cycle after its low byte is written.
- R9: While debug halt is high the count holds. A control write during a halt discards a pending modulo high byte, so a later low byte combines with the active high byte. Outside a halt, a control write keeps the pending byte.
- R10: With modulo zero, a buffered duty commits on the step from 0xFFFE to 0xFFFF, and the count wraps from 0xFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 8 | Write byte |
| dbgHalt | input | 1 | Debug halt: freezes the count |
| pwmOut | output | 1 | Channel output pin |
| count | output | 16 | Current counter value |
| dutyActive | output | 16 | Active duty value |
| modActive | output | 16 | Active modulo value |

## Verification
The bench writes a duty pair in the middle of a period and samples the active value one cycle before and one cycle after the limit-1 to limit step. A design that commits on the low-byte write would show the new value too early. A design that commits at the wrap would show it one cycle late. It leaves a lone high byte pending across several boundaries, where a design without the pair flag would commit it. It covers the center-mode duty values of limit and limit-1, where a plain compare would drop the full-high output or miscount the low window. It also exercises the halt-time control write, where keeping the pending high byte yields 0x010C instead of 0x000C, and the free-running case, where a design that compares against a zero modulo would never commit.

// File: rtl/bufpwm_pkg.sv
package bufpwm_pkg;
  parameter int CntW  = 16;
  parameter int ByteW = 8;
  parameter int AddrW = 3;

  typedef enum logic [AddrW-1:0] {
    RegCtrl   = 3'd0,
    RegModHi  = 3'd1,
    RegModLo  = 3'd2,
    RegDutyHi = 3'd3,
    RegDutyLo = 3'd4
  } regSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic            stopped;
    logic            run;
    logic            center;
    logic            loadDuty;
    logic            loadMod;
    logic [CntW-1:0] dutyBuf;
    logic [CntW-1:0] modBuf;
  } strb_t;
endpackage

// File: rtl/bufpwm_ctrl.sv
module bufpwm_ctrl
  import bufpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [ByteW-1:0] wrData,
  input  logic             dbgHalt,
  input  logic             boundary,
  input  logic [CntW-1:0]  modAct,
  output strb_t            strb
);
  localparam int HiLsb = CntW - ByteW;

  logic [1:0]      clkSel;
  logic            centerQ;
  logic            modHiPend, modReady, dutyHiPend, dutyReady;
  logic [CntW-1:0] modBuf, dutyBuf;
  logic            stopped;

  assign stopped = (clkSel == 2'd0);

  always_comb begin
    strb.stopped  = stopped;
    strb.run      = !stopped && !dbgHalt;
    strb.center   = centerQ;
    strb.loadDuty = dutyReady && !dutyHiPend && (stopped || boundary);
    strb.loadMod  = modReady && !modHiPend && (stopped || boundary);
    strb.dutyBuf  = dutyBuf;
    strb.modBuf   = modBuf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSel     <= '0;
      centerQ    <= 1'b0;
      modHiPend  <= 1'b0;
      modReady   <= 1'b0;
      dutyHiPend <= 1'b0;
      dutyReady  <= 1'b0;
      modBuf     <= '0;
      dutyBuf    <= '0;
    end else begin
      if (strb.loadMod)  modReady  <= 1'b0;
      if (strb.loadDuty) dutyReady <= 1'b0;
      if (wrEn) begin
        case (regSel_e'(wrAddr))
          RegCtrl: begin
            clkSel  <= wrData[1:0];
            centerQ <= wrData[2];
            if (dbgHalt) begin
              modHiPend <= 1'b0;
              modReady  <= 1'b0;
              modBuf    <= modAct;
            end
          end
          RegModHi: begin
            modBuf[CntW-1:HiLsb] <= wrData;
            modHiPend            <= 1'b1;
          end
          RegModLo: begin
            modBuf[ByteW-1:0] <= wrData;
            modHiPend         <= 1'b0;
            modReady          <= 1'b1;
          end
          RegDutyHi: begin
            dutyBuf[CntW-1:HiLsb] <= wrData;
            dutyHiPend            <= 1'b1;
          end
          RegDutyLo: begin
            dutyBuf[ByteW-1:0] <= wrData;
            dutyHiPend         <= 1'b0;
            dutyReady          <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bufpwm_dp.sv
module bufpwm_dp
  import bufpwm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strb_t           strb,
  output logic [CntW-1:0] cnt,
  output logic [CntW-1:0] dutyAct,
  output logic [CntW-1:0] modAct,
  output logic            boundary,
  output logic            pwmOut
);
  logic [CntW-1:0] lim;
  logic            dirUp;
  logic            fullOn;

  assign lim      = (modAct == '0) ? '1 : modAct;
  assign boundary = strb.run && (!strb.center || dirUp) && (cnt == lim - 1'b1);
  assign fullOn   = strb.center && (dutyAct >= lim);
  assign pwmOut   = fullOn || (cnt < dutyAct);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      dirUp   <= 1'b1;
      dutyAct <= '0;
      modAct  <= '0;
    end else begin
      if (strb.loadDuty) dutyAct <= strb.dutyBuf;
      if (strb.loadMod)  modAct  <= strb.modBuf;
      if (strb.run) begin
        if (!strb.center) begin
          dirUp <= 1'b1;
          cnt   <= (cnt >= lim) ? '0 : cnt + 1'b1;
        end else if (dirUp) begin
          if (cnt >= lim) begin
            dirUp <= 1'b0;
            cnt   <= cnt - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (cnt == '0) begin
          dirUp <= 1'b1;
          cnt   <= {{(CntW-1){1'b0}}, 1'b1};
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bufpwm_top.sv
module bufpwm_top
  import bufpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [ByteW-1:0] wrData,
  input  logic             dbgHalt,
  output logic             pwmOut,
  output logic [CntW-1:0]  count,
  output logic [CntW-1:0]  dutyActive,
  output logic [CntW-1:0]  modActive
);
  strb_t strb;
  logic  boundary;

  bufpwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dbgHalt(dbgHalt), .boundary(boundary), .modAct(modActive), .strb(strb)
  );

  bufpwm_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(count), .dutyAct(dutyActive),
    .modAct(modActive), .boundary(boundary), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/bufpwm_chk.sv
module bufpwm_chk
  import bufpwm_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            dbgHalt,
  input logic            stopped,
  input logic            centerMode,
  input logic            pwmOut,
  input logic [CntW-1:0] count,
  input logic [CntW-1:0] dutyActive,
  input logic [CntW-1:0] modActive
);
  logic [CntW-1:0] limC;
  assign limC = (modActive == '0) ? '1 : modActive;

  // R2: edge mode wraps to zero after the limit
  a_r2_edge_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (!stopped && !dbgHalt && !centerMode && count >= limC) |=> (count == '0));

  // R3: duty changes only at the commit step or while stopped
  a_r3_commit_point: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dutyActive) |-> ($past(stopped) || ($past(count) == $past(limC) - 1'b1)));

  // R4: zero duty keeps the pin low
  a_r4_zero_low: assert property (@(posedge clk) disable iff (!rstN)
    (dutyActive == '0) |-> !pwmOut);

  // R5: full duty in center mode is constant high
  a_r5_center_full: assert property (@(posedge clk) disable iff (!rstN)
    (centerMode && dutyActive >= limC) |-> pwmOut);

  // R6: limit-1 duty is low at the peak
  a_r6_center_near: assert property (@(posedge clk) disable iff (!rstN)
    (centerMode && limC > 1 && dutyActive == limC - 1'b1 && count == limC) |-> !pwmOut);

  // R8: stopped counter holds
  a_r8_stopped_hold: assert property (@(posedge clk) disable iff (!rstN)
    stopped |=> $stable(count));

  // R9: halt freezes the counter
  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (!rstN)
    dbgHalt |=> $stable(count));
endmodule

bind bufpwm_top bufpwm_chk u_chk (
  .clk(clk), .rstN(rstN), .dbgHalt(dbgHalt), .stopped(strb.stopped),
  .centerMode(strb.center), .pwmOut(pwmOut), .count(count),
  .dutyActive(dutyActive), .modActive(modActive)
);

// File: tb/bufpwm_top_tb.sv
`timescale 1ns/1ps
module bufpwm_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        dbgHalt = 1'b0;
  logic        pwmOut;
  logic [15:0] count, dutyActive, modActive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bufpwm_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dbgHalt(dbgHalt), .pwmOut(pwmOut), .count(count),
    .dutyActive(dutyActive), .modActive(modActive)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrDuty(input logic [15:0] v);
    wr(3'd3, v[15:8]);
    wr(3'd4, v[7:0]);
  endtask

  task automatic wrMod(input logic [15:0] v);
    wr(3'd1, v[15:8]);
    wr(3'd2, v[7:0]);
  endtask

  task automatic waitCount(input logic [15:0] v);
    for (int i = 0; i < 70000; i++) begin
      if (count == v) return;
      @(negedge clk);
    end
    chk(1'b0, "waitCount", count, v);
  endtask

  task automatic tReset();
    chk(count == 0 && dutyActive == 0 && modActive == 0 && pwmOut == 0,
        "R2 reset state", {count, dutyActive}, 0);
  endtask

  task automatic tStoppedLoad();
    wr(3'd1, 8'h00);
    @(negedge clk);
    chk(modActive == 16'h0000, "R1 high byte alone", modActive, 0);
    wr(3'd2, 8'h09);
    @(negedge clk);
    chk(modActive == 16'h0009, "R8 stopped direct load mod", modActive, 9);
    wrDuty(16'h0004);
    @(negedge clk);
    chk(dutyActive == 16'h0004, "R8 stopped direct load duty", dutyActive, 4);
    chk(count == 0, "R8 stopped count holds", count, 0);
  endtask

  task automatic tEdgeRun();
    logic [15:0] prev;
    wr(3'd0, 8'h01);
    for (int i = 0; i < 25; i++) begin
      prev = count;
      @(negedge clk);
      chk(count == ((prev == 16'd9) ? 16'd0 : prev + 16'd1), "R2 edge sequence", count, prev);
      chk(pwmOut == (count < 16'd4), "R4 edge compare", pwmOut, count < 16'd4);
    end
  endtask

  task automatic tBuffered();
    waitCount(16'd2);
    wrDuty(16'h0007);
    chk(dutyActive == 16'h0004, "R3 not applied on write", dutyActive, 4);
    waitCount(16'd8);
    chk(dutyActive == 16'h0004, "R3 held before commit", dutyActive, 4);
    @(negedge clk);
    chk(count == 16'd9 && dutyActive == 16'h0007, "R3 commit at limit", dutyActive, 7);
  endtask

  task automatic tZeroSwitch();
    waitCount(16'd1);
    wrDuty(16'h0000);
    chk(pwmOut == 1'b1, "R7 old duty finishes period", pwmOut, 1);
    waitCount(16'd9);
    waitCount(16'd3);
    chk(pwmOut == 1'b0 && dutyActive == 0, "R7 zero from next period", pwmOut, 0);
    wrDuty(16'h0005);
    chk(pwmOut == 1'b0, "R7 zero kept until commit", pwmOut, 0);
    waitCount(16'd3);
    chk(pwmOut == 1'b1, "R7 new duty after commit", pwmOut, 1);
  endtask

  task automatic tHiOnly();
    wr(3'd3, 8'h00);
    for (int k = 0; k < 3; k++) begin
      waitCount(16'd9);
      @(negedge clk);
    end
    chk(dutyActive == 16'h0005, "R1 lone high byte never commits", dutyActive, 5);
    wr(3'd4, 8'h02);
    waitCount(16'd9);
    chk(dutyActive == 16'h0002, "R1 pair completes", dutyActive, 2);
  endtask

  task automatic tCenter();
    logic [15:0] prev;
    int lows;
    wr(3'd0, 8'h00);
    wrDuty(16'h0009);
    wr(3'd0, 8'h05);
    for (int i = 0; i < 40; i++) begin
      prev = count;
      @(negedge clk);
      chk(pwmOut == 1'b1, "R5 full duty center high", pwmOut, 1);
      chk(count <= 16'd9 && (count == prev + 16'd1 || count + 16'd1 == prev),
          "R2 center sequence", count, prev);
    end
    wr(3'd0, 8'h00);
    wrDuty(16'h0008);
    wr(3'd0, 8'h05);
    waitCount(16'd0);
    lows = 0;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      if (!pwmOut) lows++;
      chk(pwmOut == (count < 16'd8), "R5 center compare", pwmOut, count < 16'd8);
    end
    chk(lows == 3, "R6 near-full low window", lows, 3);
    wr(3'd0, 8'h00);
    wrDuty(16'h0000);
    wr(3'd0, 8'h05);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(pwmOut == 1'b0, "R4 center zero duty", pwmOut, 0);
    end
  endtask

  task automatic tHalt();
    logic [15:0] held;
    wr(3'd0, 8'h01);
    @(negedge clk);
    dbgHalt = 1'b1;
    @(negedge clk);
    held = count;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(count == held, "R9 halt freezes count", count, held);
    end
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h0C);
    dbgHalt = 1'b0;
    waitCount(16'd8);
    @(negedge clk);
    chk(modActive == 16'h000C, "R9 halted ctrl write drops high byte", modActive, 16'h000C);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h09);
    waitCount(16'd11);
    @(negedge clk);
    chk(modActive == 16'h0109, "R9 ctrl write outside halt keeps byte", modActive, 16'h0109);
  endtask

  task automatic tFreeRun();
    wr(3'd0, 8'h00);
    wrMod(16'h0000);
    wrDuty(16'h0010);
    @(negedge clk);
    chk(modActive == 0 && dutyActive == 16'h0010, "R8 free-run setup", dutyActive, 16'h0010);
    wr(3'd0, 8'h01);
    wrDuty(16'h0020);
    waitCount(16'hFFFE);
    chk(dutyActive == 16'h0010, "R10 held at FFFE", dutyActive, 16'h0010);
    @(negedge clk);
    chk(count == 16'hFFFF && dutyActive == 16'h0020, "R10 commit at FFFF", dutyActive, 16'h0020);
    @(negedge clk);
    chk(count == 16'h0000, "R10 wrap after FFFF", count, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tStoppedLoad();
    tEdgeRun();
    tBuffered();
    tZeroSwitch();
    tHiOnly();
    tCenter();
    tHalt();
    tFreeRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", count, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule